// File: doc/BRIEF.md
# Single-Channel Modulo-Addressed DMA Engine

This block is one memory-to-memory DMA channel. Software programs a transfer descriptor through a small register write port: a current source and destination address, signed per-beat offsets for each side, a beat width, a circular-window size for each side, a byte count per minor loop, an iteration count for the major loop, and two signed adjustments applied when the major loop ends. A software start strobe then services one minor loop. The engine moves beats over a simple synchronous memory master: a read at the source address, then a write of that data at the destination address in the next cycle.

Each address can be confined to an aligned window of 2^n bytes. Inside that window only the low n bits of the address roll over, and the upper bits stay fixed. A small aligned source table can therefore be repeated across a larger destination. When the last minor loop of the major loop finishes, the engine applies the end adjustments to both addresses and reloads the iteration count. It also sets a sticky done flag and, if enabled, an interrupt flag. Software clears each flag by writing 1 to it.

Top module: `dmamod_chan`

## Requirements
- R1: After reset, done, irq and busy are 0 and no memory access is issued.
- R2: A beat is a read cycle at the current source address (mem_req=1, mem_we=0), followed by a write cycle at the current destination address that carries the data returned for that read. The beat width field w (register 3, bits [18:16]) gives 2^w bytes per beat, so w=2 means 4-byte beats. A minor loop of k beats keeps busy high for 2k cycles.
- R3: After every beat, the source address moves by the signed 16-bit source offset (register 2, bits [15:0]) and the destination address moves by the signed 16-bit destination offset (register 2, bits [31:16]).
- R4: A nonzero window value n keeps the address bits above bit n-1 unchanged and wraps the low n bits, so the new address is (a & ~m) | ((a + off) & m) with m = 2^n - 1. The source window is register 3, bits [4:0]. The destination window is register 3, bits [12:8]. The two are applied independently, and a value of 0 means plain linear addressing.
- R5: A start strobe accepted while idle moves the byte count in register 4 as one minor loop, then returns to idle. Each minor loop lowers the current iteration count by one.
- R6: The minor loop that ends the major loop (current count 1) adds the signed source adjustment (register 5) and the signed destination adjustment (register 6) to the advanced addresses. It also reloads the current count from the beginning count. A write to register 7 sets both counts.
- R7: The done flag is set only when a major loop completes. It stays set until a register 8 write with bit 1 equal to 1.
- R8: The irq output is set at major-loop completion only while the interrupt-enable bit (register 8, bit 0) is 1. It is cleared by a register 8 write with bit 2 equal to 1.
- R9: A start strobe that arrives while the channel is busy is ignored and does not add beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Descriptor register write strobe |
| reg_addr | input | 4 | Descriptor register index |
| reg_wdata | input | 32 | Descriptor register write data |
| sw_start | input | 1 | Software start strobe, services one minor loop |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the access |
| mem_size | output | 3 | Beat width code (2^code bytes) |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read |
| busy | output | 1 | Minor loop in progress |
| done | output | 1 | Sticky major-loop completion flag |
| irq | output | 1 | Sticky interrupt flag |

## Verification
The bound checker checks on every cycle that each write directly follows a read, and that the engine goes idle right after the last beat of a minor loop even when a start is held high. It also checks that done and irq rise only together with a major-loop completion event (irq also needs the enable bit), that a wrapping source address never changes its upper bits, and that the iteration count is reloaded at completion. Whether the data lands in the right destination words can only be shown by the bench's scenarios. The same holds for the signed offsets and negative steps, the end adjustments returning the addresses to their starting points, the multi-minor-loop sequencing, and write-1-to-clear. The bench sweeps every source window from 0 to 5 against two destination windows and both offset directions.

// File: rtl/dmamod_pkg.sv
package dmamod_pkg;
  localparam int ADDR_W = 32;
  localparam int MOD_W  = 5;
  localparam int SIZE_W = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} eng_state_e;

  // Next address: linear when win == 0, else low win bits roll inside the window
  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a,
                                                   input logic [ADDR_W-1:0] off,
                                                   input logic [MOD_W-1:0]  win);
    logic [ADDR_W-1:0] sum, keep;
    sum = a + off;
    if (win == '0) return sum;
    keep = (ADDR_W'(1) << win) - ADDR_W'(1);
    return (a & ~keep) | (sum & keep);
  endfunction

  function automatic logic [ADDR_W-1:0] beat_len(input logic [SIZE_W-1:0] w);
    return ADDR_W'(1) << w;
  endfunction

  function automatic logic [ADDR_W-1:0] sext16(input logic [15:0] v);
    return {{(ADDR_W-16){v[15]}}, v};
  endfunction
endpackage

// File: rtl/dmamod_desc.sv
module dmamod_desc
  import dmamod_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ITER_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [3:0]          reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  input  logic                beat_ev,
  input  logic                minor_ev,
  input  logic                major_ev,
  output logic [ADDR_W-1:0]   saddr,
  output logic [ADDR_W-1:0]   daddr,
  output logic [MOD_W-1:0]    smod,
  output logic [SIZE_W-1:0]   width,
  output logic [ADDR_W-1:0]   nbytes,
  output logic [ITER_W-1:0]   citer,
  output logic [ITER_W-1:0]   biter,
  output logic                int_en,
  output logic                done,
  output logic                irq
);
  logic [15:0]       soff, doff;
  logic [MOD_W-1:0]  dmod;
  logic [ADDR_W-1:0] slast, dlast;
  logic [ADDR_W-1:0] s_adj, d_adj;

  assign s_adj = major_ev ? slast : '0;
  assign d_adj = major_ev ? dlast : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      saddr <= '0; daddr <= '0; soff <= '0; doff <= '0;
      smod <= '0; dmod <= '0; width <= '0; nbytes <= '0;
      slast <= '0; dlast <= '0; citer <= '0; biter <= '0;
      int_en <= 1'b0; done <= 1'b0; irq <= 1'b0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          4'd0: saddr  <= reg_wdata[ADDR_W-1:0];
          4'd1: daddr  <= reg_wdata[ADDR_W-1:0];
          4'd2: begin soff <= reg_wdata[15:0]; doff <= reg_wdata[31:16]; end
          4'd3: begin
            smod  <= reg_wdata[MOD_W-1:0];
            dmod  <= reg_wdata[8 +: MOD_W];
            width <= reg_wdata[16 +: SIZE_W];
          end
          4'd4: nbytes <= reg_wdata[ADDR_W-1:0];
          4'd5: slast  <= reg_wdata[ADDR_W-1:0];
          4'd6: dlast  <= reg_wdata[ADDR_W-1:0];
          4'd7: begin citer <= reg_wdata[ITER_W-1:0]; biter <= reg_wdata[ITER_W-1:0]; end
          4'd8: begin
            int_en <= reg_wdata[0];
            if (reg_wdata[1]) done <= 1'b0;
            if (reg_wdata[2]) irq  <= 1'b0;
          end
          default: ;
        endcase
      end
      // engine updates take precedence over a same-cycle software write
      if (beat_ev) begin
        saddr <= step_addr(saddr, sext16(soff), smod) + s_adj;
        daddr <= step_addr(daddr, sext16(doff), dmod) + d_adj;
      end
      if (minor_ev) citer <= major_ev ? biter : citer - ITER_W'(1);
      if (major_ev) begin
        done <= 1'b1;
        if (int_en) irq <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dmamod_engine.sv
module dmamod_engine
  import dmamod_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ITER_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sw_start,
  input  logic [ADDR_W-1:0]   saddr,
  input  logic [ADDR_W-1:0]   daddr,
  input  logic [SIZE_W-1:0]   width,
  input  logic [ADDR_W-1:0]   nbytes,
  input  logic [ITER_W-1:0]   citer,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic                busy,
  output logic                beat_ev,
  output logic                minor_ev,
  output logic                major_ev,
  output logic                mem_req,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [SIZE_W-1:0]   mem_size,
  output logic [DATA_W-1:0]   mem_wdata
);
  eng_state_e        state;
  logic [ADDR_W-1:0] remain, blen;
  logic              last_beat;

  assign blen      = beat_len(width);
  assign last_beat = (remain <= blen);
  assign beat_ev   = (state == ST_WR);
  assign minor_ev  = beat_ev && last_beat;
  assign major_ev  = minor_ev && (citer <= ITER_W'(1));
  assign busy      = (state != ST_IDLE);

  assign mem_req   = busy;
  assign mem_we    = beat_ev;
  assign mem_addr  = beat_ev ? daddr : saddr;
  assign mem_size  = width;
  assign mem_wdata = mem_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      remain <= '0;
    end else begin
      case (state)
        ST_IDLE: if (sw_start) begin
          remain <= nbytes;
          state  <= ST_RD;
        end
        ST_RD: state <= ST_WR;
        ST_WR: begin
          remain <= remain - blen;
          state  <= last_beat ? ST_IDLE : ST_RD;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dmamod_chan.sv
module dmamod_chan
  import dmamod_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ITER_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              sw_start,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [SIZE_W-1:0] mem_size,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              irq
);
  logic              beat_ev, minor_ev, major_ev, int_en;
  logic [ADDR_W-1:0] saddr, daddr, nbytes;
  logic [MOD_W-1:0]  smod;
  logic [SIZE_W-1:0] width;
  logic [ITER_W-1:0] citer, biter;

  dmamod_desc #(.DATA_W(DATA_W), .ITER_W(ITER_W)) u_desc (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .beat_ev(beat_ev), .minor_ev(minor_ev),
    .major_ev(major_ev), .saddr(saddr), .daddr(daddr), .smod(smod),
    .width(width), .nbytes(nbytes), .citer(citer), .biter(biter),
    .int_en(int_en), .done(done), .irq(irq)
  );

  dmamod_engine #(.DATA_W(DATA_W), .ITER_W(ITER_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .saddr(saddr),
    .daddr(daddr), .width(width), .nbytes(nbytes), .citer(citer),
    .mem_rdata(mem_rdata), .busy(busy), .beat_ev(beat_ev),
    .minor_ev(minor_ev), .major_ev(major_ev), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata)
  );
endmodule

// File: rtl/dmamod_chan_chk.sv
module dmamod_chan_chk
  import dmamod_pkg::*;
#(
  parameter int ITER_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic              busy,
  input logic              mem_req,
  input logic              mem_we,
  input logic              beat_ev,
  input logic              minor_ev,
  input logic              major_ev,
  input logic              done,
  input logic              irq,
  input logic              int_en,
  input logic [ADDR_W-1:0] saddr,
  input logic [MOD_W-1:0]  smod,
  input logic [ITER_W-1:0] citer,
  input logic [ITER_W-1:0] biter
);
  function automatic logic [ADDR_W-1:0] upper_mask(input logic [MOD_W-1:0] n);
    return ~((ADDR_W'(1) << n) - ADDR_W'(1));
  endfunction

  p_wr_follows_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> $past(mem_req && !mem_we));

  // R9: a held start cannot keep the engine running past the last beat
  p_idle_after_minor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    minor_ev |=> !busy);

  p_src_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_ev && !major_ev && !reg_we && smod != '0) |=>
      (((saddr ^ $past(saddr)) & upper_mask($past(smod))) == '0));

  p_citer_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (major_ev && !reg_we) |=> (citer == $past(biter)));

  p_done_from_major_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(major_ev));

  p_irq_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(major_ev) && $past(int_en)));
endmodule

bind dmamod_chan dmamod_chan_chk #(.ITER_W(ITER_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .busy(busy), .mem_req(mem_req),
  .mem_we(mem_we), .beat_ev(beat_ev), .minor_ev(minor_ev), .major_ev(major_ev),
  .done(done), .irq(irq), .int_en(int_en), .saddr(saddr), .smod(smod),
  .citer(citer), .biter(biter)
);

// File: tb/dmamod_chan_test.sv
module dmamod_chan_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        sw_start = 1'b0;
  logic        mem_req, mem_we, busy, done, irq;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic [2:0]  mem_size;

  logic [31:0] mem [0:63];
  logic [31:0] expv [0:63];
  int total = 0;
  int bad = 0;
  int wcount = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  dmamod_chan uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .sw_start(sw_start), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy),
    .done(done), .irq(irq)
  );

  // synchronous word memory: read data appears the cycle after the read
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        mem[mem_addr[7:2]] <= mem_wdata;
        wcount <= wcount + 1;
      end else begin
        mem_rdata <= mem[mem_addr[7:2]];
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: run did not finish, actual cycles=%0d expected<100000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [3:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic go();
    sw_start = 1'b1;
    @(negedge clk);
    sw_start = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy) begin
      n++;
      @(negedge clk);
    end
  endtask

  function automatic logic [31:0] ref_step(input logic [31:0] a, input logic [31:0] off, input int n);
    logic [31:0] lowm;
    if (n == 0) return a + off;
    lowm = ~(32'hFFFF_FFFF << n);
    return ((a + off) & lowm) | (a & ~lowm);
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
  endtask

  initial begin
    int n;
    int wbase;
    logic [31:0] sa, da;
    clear_mem();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check(done == 0 && irq == 0 && busy == 0 && mem_req == 0, "R1 reset flags",
          {28'h0, done, irq, busy, mem_req}, 32'h0);

    // R4/R6: a 16-byte window repeats four words into eight destination words
    for (int i = 0; i < 4; i++) mem[16+i] = i + 1;
    wreg(4'd0, 32'h40); wreg(4'd1, 32'h80);
    wreg(4'd2, {16'd4, 16'd4});
    wreg(4'd3, (32'd2 << 16) | 32'd4);
    wreg(4'd4, 32'd32); wreg(4'd5, 32'd0); wreg(4'd6, -32'sd32);
    wreg(4'd7, 32'd1); wreg(4'd8, 32'h1);
    go();
    wait_idle(n);
    check(n == 16, "R2 busy cycles for 8 beats", n, 16);
    for (int i = 0; i < 8; i++)
      check(mem[32+i] == (i % 4) + 1, "R4 wrapped source pattern", mem[32+i], (i % 4) + 1);
    check(done == 1, "R7 done after major loop", done, 1);
    check(irq == 1, "R8 irq with enable", irq, 1);

    // R6: restart without reprogramming; addresses and count restored
    for (int i = 0; i < 4; i++) mem[16+i] = i + 5;
    go();
    wait_idle(n);
    for (int i = 0; i < 8; i++)
      check(mem[32+i] == (i % 4) + 5, "R6 adjust and reload", mem[32+i], (i % 4) + 5);

    // R7/R8: write-1-to-clear, each flag independently
    wreg(4'd8, 32'h3);
    check(done == 0 && irq == 1, "R7 done cleared alone", {30'h0, done, irq}, 32'h1);
    wreg(4'd8, 32'h5);
    check(irq == 0, "R8 irq cleared", irq, 0);

    // R5/R8: three minor loops of two words, interrupt disabled
    clear_mem();
    for (int i = 0; i < 8; i++) mem[16+i] = 32'hA0 + i;
    wreg(4'd8, 32'h0);
    wreg(4'd0, 32'h40); wreg(4'd1, 32'h80);
    wreg(4'd3, (32'd2 << 16));
    wreg(4'd4, 32'd8); wreg(4'd5, -32'sd24); wreg(4'd6, -32'sd24);
    wreg(4'd7, 32'd3);
    go(); wait_idle(n);
    check(done == 0 && mem[33] == 32'hA1 && mem[34] == 0, "R5 one minor loop only",
          mem[34], 0);
    go(); wait_idle(n);
    check(done == 0, "R5 not done after second minor loop", done, 0);
    go(); wait_idle(n);
    check(done == 1, "R7 done after third minor loop", done, 1);
    check(irq == 0, "R8 no irq while disabled", irq, 0);
    check(mem[37] == 32'hA5, "R5 third minor loop data", mem[37], 32'hA5);
    wreg(4'd8, 32'h6);

    // R9: start held high throughout a busy minor loop
    wreg(4'd0, 32'h40); wreg(4'd1, 32'h80);
    wreg(4'd4, 32'd16); wreg(4'd7, 32'd1);
    wbase = wcount;
    sw_start = 1'b1;
    @(negedge clk);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    sw_start = 1'b0;
    @(negedge clk);
    check(wcount - wbase == 4, "R9 start ignored while busy", wcount - wbase, 4);
    check(n == 8, "R9 no extra busy cycles", n, 8);
    wreg(4'd8, 32'h6);

    // R3/R4: sweep source window 0..5, destination window 0/3, both directions
    for (int sm = 0; sm <= 5; sm++) begin
      for (int dmi = 0; dmi < 2; dmi++) begin
        for (int dir = 0; dir < 2; dir++) begin
          int dmv;
          logic [31:0] soffv, sstart;
          bit ok;
          int badw;
          dmv = dmi * 3;
          soffv = dir ? 32'hFFFF_FFFC : 32'd4;
          sstart = dir ? 32'h5C : 32'h40;
          clear_mem();
          for (int i = 0; i < 16; i++) mem[16+i] = 100 + i;
          for (int i = 0; i < 64; i++) expv[i] = mem[i];
          sa = sstart; da = 32'h80;
          for (int b = 0; b < 8; b++) begin
            expv[da[7:2]] = expv[sa[7:2]];
            sa = ref_step(sa, soffv, sm);
            da = ref_step(da, 32'd4, dmv);
          end
          wreg(4'd0, sstart); wreg(4'd1, 32'h80);
          wreg(4'd2, {16'd4, soffv[15:0]});
          wreg(4'd3, (32'd2 << 16) | (32'(dmv) << 8) | 32'(sm));
          wreg(4'd4, 32'd32); wreg(4'd5, 32'd0); wreg(4'd6, 32'd0);
          wreg(4'd7, 32'd1);
          go(); wait_idle(n);
          ok = 1; badw = 0;
          for (int i = 32; i < 64; i++)
            if (mem[i] !== expv[i]) begin ok = 0; badw = i; end
          check(ok, $sformatf("R3 R4 sweep smod=%0d dmod=%0d dir=%0d word=%0d", sm, dmv, dir, badw),
                mem[badw], expv[badw]);
          wreg(4'd8, 32'h6);
        end
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule